// File: doc/BRIEF.md
# Raster Sync and Frame Timing Generator

This block runs from one pixel-rate clock and produces the timing for a raster display. It keeps a horizontal position counter and a scanline counter. From them it decodes four outputs:

- an active-low line sync;
- an active-low composite frame sync, which is released in the middle of a scanline rather than on a line boundary;
- a strobe that is high inside the visible pixel window, which drives pixel fetch and display;
- a level interrupt flag that rises on the first line after the visible area.

Software drops the interrupt flag through a dedicated clear input. The flag also drops by itself at the top of every frame.

Every output is a register loaded from the next counter values. The outputs therefore change on the same clock edge as the counters, and every output agrees with the position the counters hold. A synchronous active-high reset puts both counters at position 0 of line 0. It also loads the outputs with the values decoded for that position.

Top module: `raster_timing_gen`

## Requirements
- R1: A scanline lasts LINE_LEN clocks (default 1024) and a frame lasts FRAME_LINES lines (default 312). The horizontal count wraps from LINE_LEN-1 to 0 and advances the line count, and the line count wraps from FRAME_LINES-1 to 0.
- R2: hsync_n is 0 at horizontal positions 0 to HS_END-1 (default 75) of every line and 1 at all other positions.
- R3: csync_n is 0 from position 0 of line 0 up to, but not including, position CS_END_POS (default 512) of line CS_END_LINE (default 2). It is 1 from that point until the end of the frame.
- R4: active is 1 when the horizontal position is in [ACT_X0, ACT_X0+ACT_W) and the line is in [ACT_Y0, ACT_Y0+ACT_H). With the defaults these ranges are positions 256..895 and lines 38..293. Outside both ranges active is 0.
- R5: vsync_irq becomes 1 when the counters enter position 0 of line ACT_Y0+ACT_H (default 294). It then holds 1 until it is cleared.
- R6: vsync_irq becomes 0 when the counters enter position 0 of line 0.
- R7: irq_clear high at a clock edge makes vsync_irq 0 after that edge. This holds even when the same edge would set the flag.
- R8: rst high at a clock edge puts the counters at position 0 of line 0. After that edge hsync_n=0, csync_n=0, active=0 and vsync_irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_clear | input | 1 | Clears the frame interrupt flag; takes priority over a set |
| hsync_n | output | 1 | Active-low line sync |
| csync_n | output | 1 | Active-low composite frame sync |
| active | output | 1 | High inside the visible pixel window |
| vsync_irq | output | 1 | Level frame interrupt flag |

## Verification
Two functions can act on the interrupt flag in the same cycle. The first is the set at the start of the first line below the visible area. The second is a clear request from irq_clear. The bench waits until the counters sit on the last position of the line before the interrupt line. It then raises irq_clear for exactly the edge that would set the flag, and it expects the flag to stay low for the whole of that line. A second clear, issued while the flag is already high, must drop the flag after one edge. Both cases are run on a reduced geometry so that many whole frames fit in the run. A default-sized instance is checked in parallel, past the release of the composite sync and into the visible window.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Registered sync bundle
  typedef struct packed {
    logic hs_n;
    logic cs_n;
    logic act;
  } raster_sig_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int LINE_LEN = 1024,
  localparam int HW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_q,
  output logic [HW-1:0] h_nxt,
  output logic          h_wrap
);

  assign h_wrap = (h_q == HW'(LINE_LEN - 1));
  assign h_nxt  = h_wrap ? '0 : h_q + HW'(1);

  always_ff @(posedge clk) begin
    if (rst) h_q <= '0;
    else     h_q <= h_nxt;
  end

  // R1
  hwrap_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q == HW'(LINE_LEN - 1)) |=> (h_q == '0));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int FRAME_LINES = 312,
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [VW-1:0] v_q,
  output logic [VW-1:0] v_nxt
);

  logic last_line;
  assign last_line = (v_q == VW'(FRAME_LINES - 1));

  always_comb begin
    v_nxt = v_q;
    if (adv) v_nxt = last_line ? '0 : v_q + VW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= v_nxt;
  end

  // R1
  vhold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(v_q));

  // R1
  vwrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && last_line) |=> (v_q == '0));

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int HS_END = 75,
  parameter int CS_END_LINE = 2,
  parameter int CS_END_POS = 512,
  parameter int ACT_X0 = 256,
  parameter int ACT_W = 640,
  parameter int ACT_Y0 = 38,
  parameter int ACT_H = 256,
  localparam int ACT_X1 = ACT_X0 + ACT_W,
  localparam int ACT_Y1 = ACT_Y0 + ACT_H
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_nxt,
  input  logic [VW-1:0] v_nxt,
  output raster_sig_t   sig_q
);

  function automatic raster_sig_t decode(input int h, input int v);
    raster_sig_t s;
    s.hs_n = (h >= HS_END);
    s.cs_n = !((v < CS_END_LINE) || (v == CS_END_LINE && h < CS_END_POS));
    s.act  = (h >= ACT_X0) && (h < ACT_X1) && (v >= ACT_Y0) && (v < ACT_Y1);
    return s;
  endfunction

  raster_sig_t sig_d;
  assign sig_d = decode(int'(h_nxt), int'(v_nxt));

  always_ff @(posedge clk) begin
    if (rst) sig_q <= decode(0, 0);
    else     sig_q <= sig_d;
  end

endmodule

// File: rtl/raster_irq.sv
module raster_irq #(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int IRQ_LINE = 294
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [HW-1:0] h_nxt,
  input  logic [VW-1:0] v_nxt,
  output logic          irq_q
);

  logic at_line_start, hit_set, hit_top;
  assign at_line_start = (h_nxt == '0);
  assign hit_set = at_line_start && (v_nxt == VW'(IRQ_LINE));
  assign hit_top = at_line_start && (v_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)                  irq_q <= 1'b0;
    else if (clr || hit_top)  irq_q <= 1'b0;
    else if (hit_set)         irq_q <= 1'b1;
  end

  // R7
  clr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq_q);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int LINE_LEN = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HS_END = 75,
  parameter int CS_END_LINE = 2,
  parameter int CS_END_POS = 512,
  parameter int ACT_X0 = 256,
  parameter int ACT_W = 640,
  parameter int ACT_Y0 = 38,
  parameter int ACT_H = 256,
  localparam int HW = $clog2(LINE_LEN),
  localparam int VW = $clog2(FRAME_LINES),
  localparam int IRQ_LINE = ACT_Y0 + ACT_H
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_clear,
  output logic hsync_n,
  output logic csync_n,
  output logic active,
  output logic vsync_irq
);

  logic [HW-1:0] h_q, h_nxt;
  logic [VW-1:0] v_q, v_nxt;
  logic          h_wrap;
  raster_sig_t   sig_q;

  raster_hcount #(.LINE_LEN(LINE_LEN)) u_hcnt (
    .clk(clk), .rst(rst), .h_q(h_q), .h_nxt(h_nxt), .h_wrap(h_wrap)
  );

  raster_vcount #(.FRAME_LINES(FRAME_LINES)) u_vcnt (
    .clk(clk), .rst(rst), .adv(h_wrap), .v_q(v_q), .v_nxt(v_nxt)
  );

  raster_decode #(
    .HW(HW), .VW(VW), .HS_END(HS_END),
    .CS_END_LINE(CS_END_LINE), .CS_END_POS(CS_END_POS),
    .ACT_X0(ACT_X0), .ACT_W(ACT_W), .ACT_Y0(ACT_Y0), .ACT_H(ACT_H)
  ) u_dec (
    .clk(clk), .rst(rst), .h_nxt(h_nxt), .v_nxt(v_nxt), .sig_q(sig_q)
  );

  raster_irq #(.HW(HW), .VW(VW), .IRQ_LINE(IRQ_LINE)) u_irq (
    .clk(clk), .rst(rst), .clr(irq_clear),
    .h_nxt(h_nxt), .v_nxt(v_nxt), .irq_q(vsync_irq)
  );

  assign hsync_n = sig_q.hs_n;
  assign csync_n = sig_q.cs_n;
  assign active  = sig_q.act;

  // R2
  hsync_pos_chk: assert property (@(posedge clk) disable iff (rst)
    hsync_n == (int'(h_q) >= HS_END));

  // R4
  active_win_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (int'(h_q) >= ACT_X0 && int'(h_q) < ACT_X0 + ACT_W &&
                int'(v_q) >= ACT_Y0 && int'(v_q) < IRQ_LINE));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync_irq) |-> (h_q == '0 && int'(v_q) == IRQ_LINE));

  // R6
  irq_top_chk: assert property (@(posedge clk) disable iff (rst)
    (h_q == '0 && v_q == '0) |-> !vsync_irq);

  // R3
  csync_rel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csync_n) |-> (int'(v_q) == CS_END_LINE && int'(h_q) == CS_END_POS));

endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;

  // reduced geometry for the whole-frame instance
  localparam int SL = 40, SF = 20, SHS = 6, SCL = 2, SCP = 20;
  localparam int SX0 = 10, SW = 16, SY0 = 4, SH = 10;
  localparam int SIRQ = SY0 + SH;
  // default geometry
  localparam int DL = 1024, DF = 312, DHS = 75, DCL = 2, DCP = 512;
  localparam int DX0 = 256, DW = 640, DY0 = 38, DH = 256;
  localparam int DIRQ = DY0 + DH;

  logic clk = 1'b0, rst = 1'b1, clr_d = 1'b0, clr_s = 1'b0;
  logic hs_d, cs_d, act_d, irq_d;
  logic hs_s, cs_s, act_s, irq_s;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst(rst), .irq_clear(clr_d),
    .hsync_n(hs_d), .csync_n(cs_d), .active(act_d), .vsync_irq(irq_d)
  );

  raster_timing_gen #(
    .LINE_LEN(SL), .FRAME_LINES(SF), .HS_END(SHS), .CS_END_LINE(SCL),
    .CS_END_POS(SCP), .ACT_X0(SX0), .ACT_W(SW), .ACT_Y0(SY0), .ACT_H(SH)
  ) uut_s (
    .clk(clk), .rst(rst), .irq_clear(clr_s),
    .hsync_n(hs_s), .csync_n(cs_s), .active(act_s), .vsync_irq(irq_s)
  );

  // reference state
  int dh = 0, dv = 0, sh = 0, sv = 0;
  bit dirq = 0, sirq = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      dh = 0; dv = 0; sh = 0; sv = 0; dirq = 0; sirq = 0;
    end else begin
      dh++; if (dh == DL) begin dh = 0; dv++; if (dv == DF) dv = 0; end
      sh++; if (sh == SL) begin sh = 0; sv++; if (sv == SF) sv = 0; end
      if (clr_d || (dh == 0 && dv == 0)) dirq = 0;
      else if (dh == 0 && dv == DIRQ) dirq = 1;
      if (clr_s || (sh == 0 && sv == 0)) sirq = 0;
      else if (sh == 0 && sv == SIRQ) sirq = 1;
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2", "hsync_n default", hs_d, dh >= DHS);
      check("R3", "csync_n default", cs_d, !(dv < DCL || (dv == DCL && dh < DCP)));
      check("R4", "active default", act_d,
            dh >= DX0 && dh < DX0 + DW && dv >= DY0 && dv < DY0 + DH);
      check("R5", "vsync_irq default", irq_d, dirq);
      check("R2", "hsync_n reduced", hs_s, sh >= SHS);
      check("R3", "csync_n reduced", cs_s, !(sv < SCL || (sv == SCL && sh < SCP)));
      check("R4", "active reduced", act_s,
            sh >= SX0 && sh < SX0 + SW && sv >= SY0 && sv < SY0 + SH);
      check("R6", "vsync_irq reduced", irq_s, sirq);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "hsync_n at reset", hs_d, 1'b0);
    check("R8", "csync_n at reset", cs_d, 1'b0);
    check("R8", "active at reset", act_d, 1'b0);
    check("R8", "vsync_irq at reset", irq_s, 1'b0);
    rst = 1'b0;
    // R1/R5: let the reduced instance raise the flag in the first frame
    while (!(sh == 5 && sv == SIRQ)) @(negedge clk);
    check("R5", "flag set on interrupt line", irq_s, 1'b1);
    // R7: clear while the flag is high
    clr_s = 1'b1;
    @(negedge clk);
    clr_s = 1'b0;
    check("R7", "flag after clear", irq_s, 1'b0);
    // R7: clear on the same edge as the set
    while (!(sh == SL - 1 && sv == SIRQ - 1)) @(negedge clk);
    clr_s = 1'b1;
    @(negedge clk);
    clr_s = 1'b0;
    check("R7", "clear beats set", irq_s, 1'b0);
    repeat (SL - 2) @(negedge clk);
    check("R7", "flag stays low on that line", irq_s, 1'b0);
    // R1/R6: one normal frame cycle, then wrap to the top
    while (!(sh == 3 && sv == SIRQ)) @(negedge clk);
    check("R5", "flag set next frame", irq_s, 1'b1);
    while (!(sh == 1 && sv == 0)) @(negedge clk);
    check("R6", "flag dropped at frame top", irq_s, 1'b0);
    // default instance into the visible window
    while (!(dv == DY0 && dh == DX0 + 4)) @(negedge clk);
    check("R4", "default window open", act_d, 1'b1);
    repeat (DL) @(negedge clk);
    check("R1", "default line length", act_d, 1'b1);
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule